// File: doc/BRIEF.md
# PLL Clock-Select and Low-Power Controller

This block is the digital control side of a clock generator. It keeps a small control register with three fields: a PLL enable, a clock-source select and a PLL status flag. From these it drives a bus clock that is either the crystal clock or the VCO clock, each divided by two. Both clocks are modelled as activity strobes in a single system clock domain. Each strobe marks one edge of its source, and the divider toggles once per strobe of the selected source. When the selection changes, the bus clock is held low for a full period of the new source, so the switch never produces a runt pulse.

The controller reacts to three requests. A wait request leaves everything running. A stop request silences all outputs, and if the VCO path is selected at that moment it drops the selection, so the block comes back on the crystal path. A debug break request, together with a break-clear enable, decides whether software writes can clear the status flag while break is active. The analog loop, the oscillator and the lock detector are outside the block. Lock changes arrive as a single-cycle pulse.

Top module: `pll_clksel_ctrl`

## Requirements
- R1: After reset all register fields read 0, the upper read bits read 0, and the bus clock, crystal clock and interrupt outputs are low.
- R2: The register layout is: bit 0 is the PLL enable, bit 1 is the clock select (0 selects the crystal, 1 selects the VCO), and bit 2 is the status flag. While the selection is steady, the bus clock toggles one system cycle after each strobe of the selected source and ignores strobes of the other source.
- R3: The PLL enable and the clock select are separate fields. A write of 0x01 turns the PLL on and keeps the crystal path. A later write of 0x01 from the VCO path deselects the VCO and leaves the PLL enable set.
- R4: A write that sets bit 1 while its own bit 0 is 0 does not select the VCO, and bit 1 reads 0 afterwards.
- R5: After the selection changes, the bus clock is low on the next cycle. It then ignores the first HOLD_STB strobes of the new source and toggles from the following strobe onward.
- R6: A wait request changes no output, no register field and no divider behaviour.
- R7: One cycle after a stop request is sampled, the bus clock, crystal clock and interrupt outputs are low, and they stay low while the request is held.
- R8: Bit 1 reads 0 from the cycle after a stop request is sampled. After stop ends, the bus clock follows crystal strobes with no hold period, and bit 1 stays 0 until software sets it.
- R9: A lock-change pulse sets bit 2 on the next cycle, and a set wins over a clear in the same cycle. Outside break, a write with bit 2 set clears it. The interrupt output equals bit 2 except during stop.
- R10: During break with the break-clear enable at 0, a write with bit 2 set leaves the flag unchanged, while bits 0 and 1 are still written.
- R11: During break with the break-clear enable at 1, a write with bit 2 set clears the flag, and the flag stays clear after break ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_stb | input | 1 | Crystal activity strobe |
| vco_stb | input | 1 | VCO activity strobe |
| wait_req | input | 1 | Wait-mode request (level) |
| stop_req | input | 1 | Stop-mode request (level) |
| brk_active | input | 1 | Debug break in progress |
| brk_clr_en | input | 1 | Allows status clearing during break |
| lock_chg | input | 1 | Lock-change pulse that sets the status flag |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| reg_rdata | output | REG_W | Control register read data |
| xclk_out | output | 1 | Crystal clock output (registered strobe, low in stop) |
| bus_clk_out | output | 1 | Divided bus clock |
| irq_out | output | 1 | Interrupt request from the status flag |

## Verification
The bench builds the block with HOLD_STB = 3 and REG_W = 8. The hold window of three strobes then differs from the divide ratio of two, so an off-by-one in the hold count shows up as a misplaced toggle on the bus clock. The crystal and VCO strobes use different periods (every third and every second cycle), so a bench cycle model can tell which source the divider follows during switches, during wait and after wake from stop. There are no data streams at the block's edge, so all pins are plain control and status.

// File: rtl/pll_clksel_pkg.sv
package pll_clksel_pkg;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'd0,
    LPM_WAIT = 2'd1,
    LPM_STOP = 2'd2
  } lpm_e;

  localparam int FLD_ON   = 0;
  localparam int FLD_SEL  = 1;
  localparam int FLD_FLAG = 2;
  localparam int FLD_CNT  = 3;

  typedef struct packed {
    logic flag;
    logic sel;
    logic on;
  } ctl_t;

endpackage

// File: rtl/clksel_lpm.sv
module clksel_lpm
  import pll_clksel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  output logic active
);

  lpm_e mode_q, mode_d;

  // stop has priority; wait keeps the generator fully running
  always_comb begin
    if (stop_req)      mode_d = LPM_STOP;
    else if (wait_req) mode_d = LPM_WAIT;
    else               mode_d = LPM_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LPM_RUN;
    else        mode_q <= mode_d;
  end

  assign active = (mode_q != LPM_STOP);

endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
  import pll_clksel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [FLD_CNT-1:0]   wdata,
  input  logic                 brk_active,
  input  logic                 brk_clr_en,
  input  logic                 lock_chg,
  input  logic                 stop_req,
  output ctl_t                 ctl
);

  ctl_t ctl_q;
  logic clr_ok;

  // flag may be cleared outside break, or inside break when enabled
  assign clr_ok = wr_en && wdata[FLD_FLAG] && (!brk_active || brk_clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_en) begin
        ctl_q.on  <= wdata[FLD_ON];
        // the VCO can only be chosen together with a running PLL
        ctl_q.sel <= wdata[FLD_SEL] & wdata[FLD_ON];
      end
      if (stop_req) ctl_q.sel <= 1'b0;
      if (lock_chg)    ctl_q.flag <= 1'b1;
      else if (clr_ok) ctl_q.flag <= 1'b0;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
  parameter int HOLD_STB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sel,
  input  logic xtal_stb,
  input  logic vco_stb,
  output logic div_out
);

  localparam int HW = (HOLD_STB < 1) ? 1 : $clog2(HOLD_STB + 1);

  logic          div_q;
  logic          prev_q;
  logic [HW-1:0] hold_q;
  logic          stb;

  assign stb = sel ? vco_stb : xtal_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      prev_q <= 1'b0;
      hold_q <= '0;
    end else if (!active) begin
      div_q  <= 1'b0;
      hold_q <= '0;
      prev_q <= sel;
    end else if (sel != prev_q) begin
      prev_q <= sel;
      div_q  <= 1'b0;
      hold_q <= HW'(HOLD_STB);
    end else if (stb) begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      else              div_q  <= ~div_q;
    end
  end

  assign div_out = div_q;

endmodule

// File: rtl/pll_clksel_ctrl.sv
module pll_clksel_ctrl
  import pll_clksel_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int HOLD_STB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_stb,
  input  logic             vco_stb,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  input  logic             lock_chg,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             xclk_out,
  output logic             bus_clk_out,
  output logic             irq_out
);

  localparam int PAD_W = REG_W - FLD_CNT;

  logic active;
  ctl_t ctl;
  logic div_out;
  logic xclk_q;

  clksel_lpm u_lpm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_req (wait_req),
    .stop_req (stop_req),
    .active   (active)
  );

  clksel_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata[FLD_CNT-1:0]),
    .brk_active (brk_active),
    .brk_clr_en (brk_clr_en),
    .lock_chg   (lock_chg),
    .stop_req   (stop_req),
    .ctl        (ctl)
  );

  clksel_div #(.HOLD_STB(HOLD_STB)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sel      (ctl.sel),
    .xtal_stb (xtal_stb),
    .vco_stb  (vco_stb),
    .div_out  (div_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xclk_q <= 1'b0;
    else        xclk_q <= xtal_stb;
  end

  assign xclk_out    = xclk_q  & active;
  assign bus_clk_out = div_out & active;
  assign irq_out     = ctl.flag & active;

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_wr_hi;
      assign unused_wr_hi = ^reg_wdata[REG_W-1:FLD_CNT];
      assign reg_rdata = {{PAD_W{1'b0}}, ctl.flag, ctl.sel, ctl.on};
    end else begin : g_nopad
      assign reg_rdata = {ctl.flag, ctl.sel, ctl.on};
    end
  endgenerate

endmodule

// File: rtl/clksel_checker.sv
module clksel_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             brk_active,
  input logic             brk_clr_en,
  input logic             lock_chg,
  input logic [REG_W-1:0] reg_rdata,
  input logic             xclk_out,
  input logic             bus_clk_out,
  input logic             irq_out
);

  logic unused_rd_hi;
  assign unused_rd_hi = ^reg_rdata;

  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!bus_clk_out && !xclk_out && !irq_out));

  a_r8_stop_drops_sel: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !reg_rdata[1]);

  a_r4_sel_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |-> reg_rdata[0]);

  a_r9_lock_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lock_chg |=> reg_rdata[2]);

  a_r10_flag_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !brk_clr_en && !lock_chg) |=> (reg_rdata[2] == $past(reg_rdata[2])));

endmodule

bind pll_clksel_ctrl clksel_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_pll_clksel_ctrl.sv
`timescale 1ns/1ps
module sim_pll_clksel_ctrl;

  localparam int REG_W = 8;
  localparam int HOLD  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_stb = 0, vco_stb = 0, wait_req = 0, stop_req = 0;
  logic brk_active = 0, brk_clr_en = 0, lock_chg = 0, reg_wr = 0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic xclk_out, bus_clk_out, irq_out;

  always #2.5 clk = ~clk;

  pll_clksel_ctrl #(.REG_W(REG_W), .HOLD_STB(HOLD)) u0 (.*);

  typedef struct {
    logic bus;
    logic xclk;
    logic irq;
    logic [REG_W-1:0] rd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int xper = 3, vper = 2;
  bit done = 0;

  // requirement-level model state
  logic m_on = 0, m_sel = 0, m_flag = 0, m_div = 0, m_prev = 0, m_stopped = 0, m_xq = 0;
  int   m_hold = 0;

  task automatic chk(input string tag, input string what, input logic [REG_W-1:0] act,
                     input logic [REG_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // driver: one system cycle, pushes the expected outputs after the next edge
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic stb, n_on, n_sel, n_flag;
      exp_t e;
      cyc_n++;
      xtal_stb = (cyc_n % xper == 0);
      vco_stb  = (cyc_n % vper == 0);
      stb = m_sel ? vco_stb : xtal_stb;
      if (m_stopped) begin
        m_div = 0; m_hold = 0; m_prev = m_sel;
      end else if (m_sel != m_prev) begin
        m_prev = m_sel; m_div = 0; m_hold = HOLD;
      end else if (stb) begin
        if (m_hold != 0) m_hold--;
        else m_div = ~m_div;
      end
      n_on = m_on; n_sel = m_sel; n_flag = m_flag;
      if (reg_wr) begin
        n_on = reg_wdata[0];
        n_sel = reg_wdata[1] & reg_wdata[0];
      end
      if (stop_req) n_sel = 0;
      if (lock_chg) n_flag = 1;
      else if (reg_wr && reg_wdata[2] && (!brk_active || brk_clr_en)) n_flag = 0;
      m_on = n_on; m_sel = n_sel; m_flag = n_flag;
      m_xq = xtal_stb;
      m_stopped = stop_req;
      e.bus  = m_div & !m_stopped;
      e.xclk = m_xq & !m_stopped;
      e.irq  = m_flag & !m_stopped;
      e.rd   = {5'b0, m_flag, m_sel, m_on};
      e.tag  = tag;
      exp_q.push_back(e);
      @(negedge clk);
      reg_wr = 0;
      lock_chg = 0;
    end
  endtask

  task automatic wr(input logic [REG_W-1:0] d, input string tag);
    reg_wr = 1;
    reg_wdata = d;
    run(1, tag);
  endtask

  // monitor: pops and compares shortly after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "bus_clk_out", {7'b0, bus_clk_out}, {7'b0, e.bus});
      chk(e.tag, "xclk_out",    {7'b0, xclk_out},    {7'b0, e.xclk});
      chk(e.tag, "irq_out",     {7'b0, irq_out},     {7'b0, e.irq});
      chk(e.tag, "reg_rdata",   reg_rdata,           e.rd);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reg_rdata", reg_rdata, '0);
    chk("R1", "outputs", {5'b0, bus_clk_out, xclk_out, irq_out}, '0);
    rst_n = 1;
    run(2, "R1");
    // R2: crystal path, VCO strobes ignored
    run(20, "R2");
    // R3: PLL on, crystal kept
    wr(8'h01, "R3");
    run(12, "R3");
    // R5: switch to VCO with hold window
    wr(8'h03, "R5");
    run(14, "R5");
    vper = 3; xper = 2;
    run(12, "R2");
    // R3: deselect VCO, PLL stays on
    wr(8'h01, "R3");
    run(14, "R3");
    // R4: select without PLL is refused
    wr(8'h00, "R4");
    run(3, "R4");
    wr(8'h02, "R4");
    run(6, "R4");
    // R6: wait changes nothing
    xper = 3; vper = 2;
    wr(8'h03, "R6");
    run(10, "R6");
    wait_req = 1;
    run(20, "R6");
    wait_req = 0;
    run(4, "R6");
    // R7/R8: stop while VCO drives
    lock_chg = 1;
    run(1, "R9");
    stop_req = 1;
    run(10, "R7");
    stop_req = 0;
    run(16, "R8");
    wr(8'h05, "R9");
    run(3, "R9");
    // R9: lock sets flag, write clears; set wins over clear
    lock_chg = 1;
    run(2, "R9");
    lock_chg = 1; reg_wr = 1; reg_wdata = 8'h05;
    run(2, "R9");
    wr(8'h05, "R9");
    run(2, "R9");
    // R10: break guards the flag
    lock_chg = 1;
    run(1, "R10");
    brk_active = 1; brk_clr_en = 0;
    wr(8'h07, "R10");
    run(4, "R10");
    // R11: break with clearing enabled
    brk_clr_en = 1;
    wr(8'h07, "R11");
    run(2, "R11");
    brk_active = 0; brk_clr_en = 0;
    run(6, "R11");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule